// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external asynchronous static RAM with a 19-bit word address and a 16-bit data bus. A requester presents one word operation at a time over a valid/ready handshake: an address, write data, a 2-bit lane mask and a read/write flag. The controller then steps the memory's select, write strobe, output enable and per-byte lane enables through a fixed sequence. Read data comes back with a one-cycle response pulse. Writes return no response.

Every analog timing limit of the memory is a nanosecond parameter. Each is converted to whole clock cycles, rounded up with a floor of one, against a clock period parameter. The same RTL can therefore be retargeted to another clock or memory speed grade by changing parameters only.

Writes are ended by the write strobe rising. The data bus is driven only while the memory is guaranteed to have released it. Between requests the memory is left deselected, in its standby state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, the controller shows req_ready=1 and drives mem_sel_n=1, mem_sel=0, mem_hi_n=1, mem_lo_n=1, mem_wr_n=1, mem_rd_n=1, mem_dq_oe=0. This is also the state right after reset.
- R2: A write with a nonzero mask does the following for the whole write:
  - It selects the memory (mem_sel_n=0, mem_sel=1) and drives the address.
  - It drives each lane enable low whose mask bit is 1. Mask bit 0 maps to mem_lo_n, data bits 7:0. Mask bit 1 maps to mem_hi_n, data bits 15:8.
  - It holds mem_wr_n low for at least max(ceil(50/T), ceil(60/T), ceil(25/T)+ceil(30/T)) cycles, so the selected lanes at that address take the write data. T is the clock period in ns.
- R3: During a write, mem_dq_oe does not rise until mem_wr_n has been low for ceil(25/T) cycles. The write data is then driven, unchanged, for at least ceil(30/T) cycles before mem_wr_n rises.
- R4: A write keeps the memory selected for at least ceil(70/T) cycles in total.
- R5: A read does the following:
  - It selects the memory and drives mem_rd_n=0 with mem_wr_n=1 and mem_dq_oe=0, for max(ceil(70/T), ceil(35/T)) cycles.
  - It samples mem_dq_in on the last of those cycles.
  - It pulses rsp_valid for exactly one cycle, in the cycle after that sample.
- R6: In rsp_rdata, a lane whose mask bit is 0 reads as zero.
- R7: A write with mask 2'b00 is accepted, leaves req_ready high in the next cycle, and never drives mem_wr_n low.
- R8: After mem_rd_n rises, mem_dq_oe stays 0 for at least ceil(25/T) cycles.
- R9: mem_dq_oe is never 1 while mem_rd_n is 0.
- R10: req_ready is 0 from the cycle after a request with nonzero mask is accepted until its sequence ends. The memory is never selected while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_sel | output | 1 | Memory select, active high |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Output enable, active low |
| mem_hi_n | output | 1 | High byte lane enable, active low |
| mem_lo_n | output | 1 | Low byte lane enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
A memory model in the bench returns a poison word until the read has lasted the full access time, so a read that samples early is told apart from a correct one. Directed cases cover the following:
- the two address extremes;
- each single-lane mask and the empty mask;
- back-to-back writes;
- a read followed at once by a write, which exercises the bus turnaround.

Random mixes of reads and writes over a small address pool then compare every read with a shadow memory kept from the requests. While this runs, pin monitors measure:
- the strobe width;
- the gap between the strobe falling and the data drive starting;
- the data setup time;
- the length of each select window;
- the turnaround gap after a read.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_WC_NS       = 70,
  parameter int T_RC_NS       = 70,
  parameter int T_PWE_NS      = 50,
  parameter int T_SCE_NS      = 60,
  parameter int T_AW_NS       = 60,
  parameter int T_SD_NS       = 30,
  parameter int T_AA_NS       = 70,
  parameter int T_DOE_NS      = 35,
  parameter int T_HZWE_NS     = 25,
  parameter int T_HZOE_NS     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_wr_n,
  output logic              mem_rd_n,
  output logic              mem_hi_n,
  output logic              mem_lo_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_PWE  = cyc(T_PWE_NS);
  localparam int N_HZWE = cyc(T_HZWE_NS);
  localparam int N_SD   = cyc(T_SD_NS);
  localparam int N_AW   = max2(cyc(T_AW_NS), cyc(T_SCE_NS));
  localparam int N_WE   = max2(max2(N_PWE, N_AW), N_HZWE + N_SD);
  localparam int N_WREC = max2(1, cyc(T_WC_NS) - N_WE);
  localparam int N_RD   = max2(max2(cyc(T_AA_NS), cyc(T_DOE_NS)), cyc(T_RC_NS));
  localparam int N_TURN = cyc(T_HZOE_NS);
  localparam int N_MAX  = max2(max2(N_WE, N_WREC), max2(N_RD, N_TURN));
  localparam int CW     = $clog2(N_MAX + 2);
  localparam int LW     = DATA_W / 2;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WREC, S_RD, S_TURN} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;
  logic              selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          cnt     <= '0;
          if (!req_write)          state <= S_RD;
          else if (req_be != 2'b00) state <= S_WR;
        end
        S_WR: if (cnt == CW'(N_WE - 1)) begin
          state <= S_WREC; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_WREC: if (cnt == CW'(N_WREC - 1)) begin
          state <= S_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_RD: if (cnt == CW'(N_RD - 1)) begin
          state   <= S_TURN;
          cnt     <= '0;
          rsp_q   <= 1'b1;
          rdata_q <= {be_q[1] ? mem_dq_in[DATA_W-1:LW] : {LW{1'b0}},
                      be_q[0] ? mem_dq_in[LW-1:0]      : {LW{1'b0}}};
        end else cnt <= cnt + 1'b1;
        S_TURN: if (cnt == CW'(N_TURN - 1)) begin
          state <= S_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign selected   = (state == S_WR) || (state == S_WREC) || (state == S_RD);
  assign req_ready  = (state == S_IDLE);
  assign mem_sel_n  = !selected;
  assign mem_sel    = selected;
  assign mem_hi_n   = !(selected && be_q[1]);
  assign mem_lo_n   = !(selected && be_q[0]);
  assign mem_wr_n   = (state != S_WR);
  assign mem_rd_n   = (state != S_RD);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (state == S_WR) && (cnt >= CW'(N_HZWE));
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  logic [CW-1:0] we_low_cnt, drv_cnt, oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt  <= '0;
      drv_cnt     <= '0;
      oe_high_cnt <= CW'(N_MAX + 1);
    end else begin
      we_low_cnt  <= !mem_wr_n ? ((we_low_cnt == CW'(N_MAX + 1)) ? we_low_cnt : we_low_cnt + 1'b1) : '0;
      drv_cnt     <= mem_dq_oe ? ((drv_cnt == CW'(N_MAX + 1)) ? drv_cnt : drv_cnt + 1'b1) : '0;
      oe_high_cnt <= !mem_rd_n ? '0 : ((oe_high_cnt == CW'(N_MAX + 1)) ? oe_high_cnt : oe_high_cnt + 1'b1);
    end
  end

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_hi_n && mem_lo_n && mem_wr_n && mem_rd_n && !mem_dq_oe));

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (we_low_cnt >= CW'(N_PWE)) && (we_low_cnt >= CW'(N_AW)));

  assert_drive_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (we_low_cnt >= CW'(N_HZWE)));

  assert_data_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_n) |-> (drv_cnt >= CW'(N_SD)));

  assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_rd_n));

  assert_zero_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_be == 2'b00) |=> (mem_wr_n && req_ready));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (oe_high_cnt >= CW'(N_TURN)));

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_rd_n));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (!req_write || req_be != 2'b00)) |=> !req_ready);

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int CLK_PERIOD_NS = 10;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int PWE_C = 5;
  localparam int HZ_C  = 3;
  localparam int SD_C  = 3;
  localparam int AWC_C = 6;
  localparam int WC_C  = 7;
  localparam int RD_C  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD_NS/2) clk = ~clk;

  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [1:0]    req_be;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_hi_n, mem_lo_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] model_dq = '0;

  sram_async_ctrl #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
    .mem_hi_n(mem_hi_n), .mem_lo_n(mem_lo_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(model_dq)
  );

  int checks = 0;
  int errs = 0;
  logic [DW-1:0] sram_mem [int unsigned];
  logic [DW-1:0] ref_mem  [int unsigned];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int rd_age = 0;
  always @(posedge clk) rd_age <= (!mem_sel_n && mem_sel && !mem_rd_n) ? rd_age + 1 : 0;

  int we_low = 0, drv_run = 0, sel_run = 0, oe_high = 99, we_falls = 0;
  bit sel_wrote = 0;
  logic [DW-1:0] pend = '0;
  logic [1:0] pend_be = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_sel_n && mem_sel && !mem_rd_n && mem_wr_n)
        model_dq <= (rd_age >= RD_C - 1) ?
                    (sram_mem.exists(int'(mem_addr)) ? sram_mem[int'(mem_addr)] : '0) : 16'hBAD0;
      else
        model_dq <= '0;
      if (mem_dq_oe && !mem_rd_n) chk(0, "R9 drive during output enable", 1, 0);
      if (mem_dq_oe && oe_high < HZ_C) chk(0, "R8 drive too soon after read", oe_high, HZ_C);
      if (!mem_wr_n) begin
        if (we_low == 0) we_falls++;
        if (mem_dq_oe && we_low < HZ_C) chk(0, "R3 drive before release", we_low, HZ_C);
        if (mem_dq_oe) begin
          if (drv_run > 0 && mem_dq_out != pend) chk(0, "R3 data changed", mem_dq_out, pend);
          pend = mem_dq_out;
          drv_run++;
        end
        pend_be = {~mem_hi_n, ~mem_lo_n};
        we_low++;
        sel_wrote = 1;
      end else if (we_low > 0) begin
        chk(we_low >= PWE_C, "R2 strobe width", we_low, PWE_C);
        chk(sel_run >= AWC_C, "R2 select before strobe end", sel_run, AWC_C);
        chk(drv_run >= SD_C, "R3 data setup", drv_run, SD_C);
        begin
          logic [DW-1:0] w;
          w = sram_mem.exists(int'(mem_addr)) ? sram_mem[int'(mem_addr)] : '0;
          if (pend_be[0]) w[7:0] = pend[7:0];
          if (pend_be[1]) w[15:8] = pend[15:8];
          sram_mem[int'(mem_addr)] = w;
        end
        we_low = 0;
        drv_run = 0;
      end
      oe_high = !mem_rd_n ? 0 : ((oe_high < 99) ? oe_high + 1 : oe_high);
      if (!mem_sel_n && mem_sel) sel_run++;
      else if (sel_run > 0) begin
        if (sel_wrote) chk(sel_run >= WC_C, "R4 write select window", sel_run, WC_C);
        else chk(sel_run >= RD_C, "R5 read select window", sel_run, RD_C);
        sel_run = 0;
        sel_wrote = 0;
      end
    end
  end

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [1:0] be);
    logic [DW-1:0] w;
    w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
    if (!be[0]) w[7:0] = '0;
    if (!be[1]) w[15:8] = '0;
    return w;
  endfunction

  task automatic check_idle(input string tag);
    int t = 0;
    while (!req_ready && t < 50) begin @(negedge clk); t++; end
    chk(req_ready && mem_sel_n && !mem_sel && mem_hi_n && mem_lo_n && mem_wr_n && mem_rd_n && !mem_dq_oe,
        tag, {mem_sel_n, mem_sel, mem_hi_n, mem_lo_n, mem_wr_n, mem_rd_n, mem_dq_oe}, 7'b1011110);
  endtask

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    int t;
    logic [DW-1:0] w;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == (wr && be == 2'b00), (wr && be == 2'b00) ? "R7 ready after empty write" : "R10 busy",
        req_ready, (wr && be == 2'b00));
    if (wr) begin
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
      if (be[0]) w[7:0] = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[int'(a)] = w;
    end else begin
      t = 0;
      while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
      chk(rsp_valid && rsp_rdata == exp_read(a, be), be == 2'b11 ? "R5 read data" : "R6 masked read data",
          rsp_rdata, exp_read(a, be));
      @(negedge clk);
      chk(!rsp_valid, "R5 response pulse width", rsp_valid, 0);
    end
  endtask

  initial begin
    int f0;
    logic [AW-1:0] pool [16];
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 reset state");

    do_req(1, 19'h00000, 16'hA55A, 2'b11);
    do_req(0, 19'h00000, 16'h0, 2'b11);
    do_req(1, 19'h7FFFF, 16'h1234, 2'b11);
    do_req(1, 19'h7FFFF, 16'hBEEF, 2'b10);
    do_req(0, 19'h7FFFF, 16'h0, 2'b11);
    do_req(1, 19'h00010, 16'hFFFF, 2'b11);
    do_req(1, 19'h00010, 16'h00C3, 2'b01);
    do_req(0, 19'h00010, 16'h0, 2'b11);
    do_req(0, 19'h00010, 16'h0, 2'b01);
    do_req(0, 19'h00010, 16'h0, 2'b10);
    f0 = we_falls;
    do_req(1, 19'h00010, 16'h7777, 2'b00);
    chk(we_falls == f0, "R7 no strobe for empty mask", we_falls, f0);
    do_req(0, 19'h00010, 16'h0, 2'b11);
    check_idle("R1 idle after directed");

    for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
    pool[0] = '0; pool[1] = '1;
    for (int i = 0; i < 250; i++) begin
      logic [AW-1:0] a;
      a = pool[$urandom_range(15)];
      if ($urandom_range(1)) do_req(1, a, DW'($urandom), 2'($urandom));
      else do_req(0, a, '0, 2'($urandom));
      if (i % 10 == 0) check_idle("R1 idle between requests");
    end
    check_idle("R1 idle at end");
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule